// File: doc/BRIEF.md
# Glitch-Free Output Clock Gate

This block drives one output clock path from a fast source clock. The output is produced by a counting divider whose output flop toggles every `HALF_CYCLES` source cycles. A small set of control fields can stop that output without a glitch: holding it at a static low or high level, squelching it while an internal calibration is busy, or disabling it. An always-on bit keeps the output running through calibration. A status output reports whether the output is toggling at this moment.

The control fields are plain input ports and may change at any time. They first pass through a two-flop synchronizer. A priority decoder then turns them into one of three targets: run, park low or park high. The divider only stops once its output already sits at the target level. Until then it finishes the half period it is in. When it resumes, it starts a full half period. Because of this, no output level ever lasts for less than `HALF_CYCLES` source cycles.

Top module: `outclk_gate`

## Requirements
- R1: With disable low and no squelch condition, hold codes 2'b00 and 2'b11 both let the output run: `clk_o` toggles after every `HALF_CYCLES` rising edges of `clk_i`.
- R2: Hold code 2'b01 parks `clk_o` at 0. If the output is high when the code takes effect, it first completes its current high level.
- R3: Hold code 2'b10 parks `clk_o` at 1. If the output is low when the code takes effect, it first completes its current low level.
- R4: No level of `clk_o` lasts for fewer than `HALF_CYCLES` cycles. This applies when entering a park, when leaving one and when running. After a park ends, the first new level lasts exactly `HALF_CYCLES` cycles.
- R5: With the squelch enable at 1, calibration busy at 1 and always-on at 0, `clk_o` parks at 0. With the squelch enable at 0, the output keeps running while calibration is busy.
- R6: Always-on at 1 overrides the calibration squelch, so the output runs while calibration is busy.
- R7: Disable at 1 parks `clk_o` at 0 and freezes the divider count. It wins over hold code 2'b10 and over the squelch and always-on inputs.
- R8: `running_o` is 1 exactly while the divider is advancing. It is 0 from the rising edge at which the output settles at a park level.
- R9: A change on a control input takes effect at the third rising edge of `clk_i` after the change: two synchronizer stages, then the divider.
- R10: While `rst_ni` is low, `clk_o` and `running_o` are 0. The synchronizer leaves reset in the run target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cal_busy_i | input | 1 | Calibration in progress |
| squelch_en_i | input | 1 | Park low while calibration is busy |
| always_on_i | input | 1 | Keep running regardless of calibration |
| hold_sel_i | input | 2 | 00 run, 01 park low, 10 park high, 11 run |
| disable_i | input | 1 | Power down the path: park low and freeze divider |
| clk_o | output | 1 | Divided, gated output clock |
| running_o | output | 1 | High while the output is toggling |

## Verification
A control change first shows in the outputs in the cycle that follows the third rising edge after the bench drives it. That latency comes from two synchronizer stages and one divider register. The scoreboard's reference pushes one expected `clk_o`/`running_o` pair per rising edge, built from inputs delayed through its own two-deep pipeline. The monitor compares each pair at the following falling edge. This keeps every comparison, including the wind-down to a park level and the full first half period after a resume, aligned to the exact edge on which it is due. A separate pulse-width tracker measures every level of `clk_o` in cycles and checks it against `HALF_CYCLES`.

// File: rtl/outclk_gate_pkg.sv
package outclk_gate_pkg;

  typedef enum logic [1:0] {
    TGT_RUN = 2'd0,
    TGT_LO  = 2'd1,
    TGT_HI  = 2'd2
  } tgt_e;

  localparam logic [1:0] HOLD_LO = 2'b01;
  localparam logic [1:0] HOLD_HI = 2'b10;

  typedef struct packed {
    logic       dis;
    logic [1:0] hold;
    logic       sq_en;
    logic       aon;
    logic       cal;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

endpackage

// File: rtl/outclk_gate_sync.sv
module outclk_gate_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[s] <= '0;
      end else if (s == 0) begin
        stg_q[s] <= d_i;
      end else begin
        stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/outclk_gate_decode.sv
module outclk_gate_decode
  import outclk_gate_pkg::*;
(
  input  ctl_t ctl_i,
  output tgt_e tgt_o
);

  // priority: disable > hold code > calibration squelch > run
  always_comb begin
    if (ctl_i.dis) begin
      tgt_o = TGT_LO;
    end else if (ctl_i.hold == HOLD_LO) begin
      tgt_o = TGT_LO;
    end else if (ctl_i.hold == HOLD_HI) begin
      tgt_o = TGT_HI;
    end else if (ctl_i.sq_en && ctl_i.cal && !ctl_i.aon) begin
      tgt_o = TGT_LO;
    end else begin
      tgt_o = TGT_RUN;
    end
  end

endmodule

// File: rtl/outclk_gate_div.sv
module outclk_gate_div
  import outclk_gate_pkg::*;
#(
  parameter int unsigned HALF_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  tgt_e tgt_i,
  output logic clk_o,
  output logic running_o
);

  localparam int unsigned CW = (HALF_CYCLES < 2) ? 1 : $clog2(HALF_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;
  logic          run_q, run_d;
  logic          park_lvl;
  logic          advance;

  assign park_lvl = (tgt_i == TGT_HI);
  // keep counting until the output already sits at the park level
  assign advance  = (tgt_i == TGT_RUN) || (out_q != park_lvl);

  always_comb begin
    cnt_d = '0;
    out_d = out_q;
    if (advance) begin
      if (cnt_q == LAST) begin
        out_d = ~out_q;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
    run_d = (tgt_i == TGT_RUN) || (out_d != park_lvl);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
      run_q <= run_d;
    end
  end

  assign clk_o     = out_q;
  assign running_o = run_q;

endmodule

// File: rtl/outclk_gate.sv
module outclk_gate
  import outclk_gate_pkg::*;
#(
  parameter int unsigned HALF_CYCLES = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cal_busy_i,
  input  logic       squelch_en_i,
  input  logic       always_on_i,
  input  logic [1:0] hold_sel_i,
  input  logic       disable_i,
  output logic       clk_o,
  output logic       running_o
);

  ctl_t ctl_raw, ctl_s;
  tgt_e tgt;
  logic dis_s;

  always_comb begin
    ctl_raw.dis   = disable_i;
    ctl_raw.hold  = hold_sel_i;
    ctl_raw.sq_en = squelch_en_i;
    ctl_raw.aon   = always_on_i;
    ctl_raw.cal   = cal_busy_i;
  end

  outclk_gate_sync #(
    .W      (CTL_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctl_raw),
    .q_o    (ctl_s)
  );

  outclk_gate_decode u_dec (
    .ctl_i (ctl_s),
    .tgt_o (tgt)
  );

  outclk_gate_div #(
    .HALF_CYCLES (HALF_CYCLES)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tgt_i     (tgt),
    .clk_o     (clk_o),
    .running_o (running_o)
  );

  assign dis_s = ctl_s.dis;

endmodule

// File: rtl/outclk_gate_chk.sv
module outclk_gate_chk
  import outclk_gate_pkg::*;
#(
  parameter int unsigned HALF_CYCLES = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_o_i,
  input logic running_o_i,
  input tgt_e tgt_i,
  input logic dis_s_i
);

  localparam int unsigned LW = $clog2(HALF_CYCLES + 2);
  localparam logic [LW-1:0] LMAX = LW'(HALF_CYCLES);

  logic [LW-1:0] len_q;
  logic          prev_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= LMAX;
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      prev_q  <= clk_o_i;
      if (clk_o_i != prev_q) len_q <= LW'(1);
      else if (len_q < LMAX) len_q <= len_q + LW'(1);
    end
  end

  p_min_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_o_i != prev_q) |-> (len_q >= LMAX));

  p_run_active_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(tgt_i) == TGT_RUN) |-> running_o_i);

  p_park_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (($past(tgt_i) == TGT_LO) && !running_o_i) |-> !clk_o_i);

  p_park_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (($past(tgt_i) == TGT_HI) && !running_o_i) |-> clk_o_i);

  p_disabled_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    ($past(dis_s_i) && !running_o_i) |-> !clk_o_i);

  p_dis_priority_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_s_i |-> (tgt_i == TGT_LO));

endmodule

bind outclk_gate outclk_gate_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clk_o_i     (clk_o),
  .running_o_i (running_o),
  .tgt_i       (tgt),
  .dis_s_i     (dis_s)
);

// File: tb/tb_outclk_gate.sv
module tb_outclk_gate;

  localparam int unsigned H = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cal_busy = 1'b0;
  logic       squelch_en = 1'b0;
  logic       always_on = 1'b0;
  logic [1:0] hold_sel = 2'b00;
  logic       disable_b = 1'b0;
  logic       clk_o;
  logic       running_o;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R10";

  typedef struct packed {
    logic       dis;
    logic [1:0] hold;
    logic       sq;
    logic       aon;
    logic       cal;
  } mctl_t;

  typedef struct packed {
    logic clk;
    logic run;
  } exp_t;

  exp_t  exp_q[$];
  mctl_t m_s1 = '0, m_s2 = '0;
  logic  m_out = 1'b0, m_run = 1'b0;
  int    m_cnt = 0;

  always #2 clk = ~clk;

  outclk_gate #(.HALF_CYCLES(H)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cal_busy_i   (cal_busy),
    .squelch_en_i (squelch_en),
    .always_on_i  (always_on),
    .hold_sel_i   (hold_sel),
    .disable_i    (disable_b),
    .clk_o        (clk_o),
    .running_o    (running_o)
  );

  // 0 run, 1 park low, 2 park high
  function automatic int target(mctl_t c);
    if (c.dis) return 1;
    if (c.hold == 2'b01) return 1;
    if (c.hold == 2'b10) return 2;
    if (c.sq && c.cal && !c.aon) return 1;
    return 0;
  endfunction

  task automatic model_step();
    int   t;
    logic lvl;
    mctl_t cur;
    t   = target(m_s2);
    lvl = (t == 2);
    if (t == 0 || m_out != lvl) begin
      if (m_cnt == H - 1) begin
        m_cnt = 0;
        m_out = ~m_out;
      end else begin
        m_cnt++;
      end
    end else begin
      m_cnt = 0;
    end
    m_run = (t == 0) || (m_out != lvl);
    cur = '{dis: disable_b, hold: hold_sel, sq: squelch_en, aon: always_on, cal: cal_busy};
    m_s2 = m_s1;
    m_s1 = cur;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      exp_q.push_back('{clk: m_out, run: m_run});
      @(negedge clk);
    end
  endtask

  task automatic check(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // scoreboard monitor plus pulse-width tracker
  int   lvl_len = 1000;
  logic lvl_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(cur_req, clk_o, e.clk, "clk_o");
        check("R8", running_o, e.run, "running_o");
      end
      if (clk_o !== lvl_prev) begin
        n_chk++;
        if (lvl_len < int'(H)) begin
          n_fail++;
          $display("FAIL R4 level width: actual %0d expected >= %0d", lvl_len, H);
        end
        lvl_len = 1;
      end else begin
        lvl_len++;
      end
      lvl_prev = clk_o;
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10", clk_o, 1'b0, "clk_o in reset");
    check("R10", running_o, 1'b0, "running_o in reset");
    rst_n = 1'b1;

    cur_req = "R1";  hold_sel = 2'b00; cyc(20);
    cur_req = "R1";  hold_sel = 2'b11; cyc(20);
    cur_req = "R2";  hold_sel = 2'b01; cyc(16);
    cur_req = "R4";  hold_sel = 2'b00; cyc(11);
    cur_req = "R3";  hold_sel = 2'b10; cyc(16);
    cur_req = "R4";  hold_sel = 2'b00; cyc(13);
    cur_req = "R2";  hold_sel = 2'b01; cyc(2);
    cur_req = "R3";  hold_sel = 2'b10; cyc(14);
    hold_sel = 2'b00;
    cur_req = "R5";  squelch_en = 1'b1; cal_busy = 1'b1; cyc(16);
    cur_req = "R5";  cal_busy = 1'b0; cyc(12);
    cur_req = "R5";  squelch_en = 1'b0; cal_busy = 1'b1; cyc(14);
    cur_req = "R6";  squelch_en = 1'b1; always_on = 1'b1; cyc(14);
    cur_req = "R7";  disable_b = 1'b1; hold_sel = 2'b10; cyc(16);
    cur_req = "R7";  always_on = 1'b0; cyc(8);
    cur_req = "R4";  disable_b = 1'b0; hold_sel = 2'b00; cal_busy = 1'b0; cyc(13);
    // R9 single-cycle pulses exercise the exact three-edge latency
    for (int k = 0; k < 6; k++) begin
      cur_req = "R9";
      disable_b = 1'b1; cyc(1);
      disable_b = 1'b0; cyc(k + 1);
      hold_sel = 2'b10; cyc(1);
      hold_sel = 2'b00; cyc(2);
    end
    cur_req = "R9"; cyc(12);

    // R10 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", clk_o, 1'b0, "clk_o after reset");
    check("R10", running_o, 1'b0, "running_o after reset");
    exp_q.delete();
    m_s1 = '0; m_s2 = '0; m_out = 1'b0; m_run = 1'b0; m_cnt = 0;
    lvl_len = 1000; lvl_prev = 1'b0;
    rst_n = 1'b1;
    cur_req = "R1"; cyc(12);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule